// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog Timer

This block is a memory-mapped watchdog that software reaches over a simple 32-bit word bus. A timebase counter runs freely from reset, and software can read it to confirm that the clock is alive. A separate interval counter measures windows of 2^N clock cycles. It runs only while the watchdog is armed. Arming takes two enable bits, and each one lives in a different register. A single stray write therefore cannot start the watchdog.

Expiry happens in two stages. When the first interval runs out, the block sets a state flag and raises an interrupt level. When a second interval runs out with that flag still set, the block latches a reset-status flag and drives a fixed-width reset pulse. Software services the watchdog by writing ones to either flag bit. That write clears the flags and starts a new interval. A build-time option locks the enables once the watchdog is armed, so that software cannot turn it off.

Top module: `wdt_twostage`

## Requirements
- R1: Word offset 0x0 is a control/status register. Bit 3 is the reset-status flag, bit 2 is the state flag, bit 1 is the first enable and bit 0 reads back the second enable. Offset 0x4 holds the second enable in bit 0. Offset 0x8 reads the timebase. Every other offset and every unused bit reads zero. After reset, all flags and enables read zero.
- R2: The timebase restarts from zero at reset and increments once per clock, so two reads taken at different cycles return different values.
- R3: The interval counter advances only while both enables are set. Clearing either enable stops the counter and discards the partial interval.
- R4: The state flag is set exactly 2^N cycles after the watchdog becomes armed, and the interrupt output follows the state flag.
- R5: If an interval expires while the state flag is already set, the reset-status flag is set and the reset output stays high for RST_CYCLES consecutive cycles.
- R6: A write to offset 0x0 with a one in bit 2 or bit 3 clears the flags that carry ones and restarts the interval. This service write takes priority over an expiry in the same cycle.
- R7: A write to offset 0x0 with zeros in bits 2 and 3 leaves both flags unchanged.
- R8: When ENABLE_ONCE is set and the watchdog is armed, writes that would clear either enable are ignored.
- R9: The interrupt drops in the cycle after a write that clears the state flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational, no side effect) |
| irq | output | 1 | Interrupt level, high while the state flag is set |
| wdt_rst | output | 1 | Reset pulse issued on the second expiry |

## Verification
The assertions check several relations on every cycle. The state flag can rise only while the watchdog is armed. The reset-status flag can rise only while the state flag is set. A service write always leaves the state flag clear, and a write with zero flag bits keeps it set. The timebase steps by one each cycle, the interval counter wraps after an expiry, the reset pulse starts after it is triggered, and a locked watchdog stays armed. Some behaviour can only be shown by the bench's scenarios against its cycle model. These are the exact 2^N and 2×2^N expiry cycles, the pulse width, arming with one enable missing, the service write landing in the very cycle of an expiry, and the effect of the lock on read-back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Byte offsets of the word registers
    localparam int unsigned OFF_CTRL  = 0;
    localparam int unsigned OFF_ARM   = 4;
    localparam int unsigned OFF_TBASE = 8;

    // Bit positions in the control/status word
    localparam int unsigned BIT_RSTF  = 3;
    localparam int unsigned BIT_STATE = 2;
    localparam int unsigned BIT_EN1   = 1;
    localparam int unsigned BIT_EN2   = 0;

    typedef struct packed {
        logic rstf;
        logic state;
        logic en1;
        logic en2;
    } wdt_ctl_t;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int unsigned TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] value_o
);
    logic [TB_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value_o = cnt_q;

    assert_timebase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
    parameter int unsigned INTERVAL_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic ovf_o
);
    logic [INTERVAL_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        ovf_o = run_i && !restart_i && (&cnt_q);
        if (!run_i || restart_i) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_wrap_after_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0));
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic rst_o
);
    localparam int unsigned CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start_i)          cnt_d = CW'(RST_CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else                  cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rst_o = (cnt_q != '0);

    assert_pulse_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> rst_o);
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned INTERVAL_LOG2 = 8,
    parameter int unsigned RST_CYCLES    = 16,
    parameter int unsigned TB_W          = 32,
    parameter bit          ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wdt_rst
);
    wdt_ctl_t ctl_d, ctl_q;

    logic              sel_ctrl, sel_arm, sel_tbase;
    logic              wr_ctrl, wr_arm, kick, armed, locked;
    logic              ovf, second_hit;
    logic [TB_W-1:0]   tb_value;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[31:4];

    assign sel_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_arm   = (bus_addr == ADDR_W'(OFF_ARM));
    assign sel_tbase = (bus_addr == ADDR_W'(OFF_TBASE));
    assign wr_ctrl   = bus_wr && sel_ctrl;
    assign wr_arm    = bus_wr && sel_arm;
    assign kick      = wr_ctrl && (bus_wdata[BIT_STATE] || bus_wdata[BIT_RSTF]);
    assign armed     = ctl_q.en1 && ctl_q.en2;
    assign locked    = ENABLE_ONCE && armed;

    wdt_timebase #(.TB_W(TB_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_o (tb_value)
    );

    wdt_interval #(.INTERVAL_LOG2(INTERVAL_LOG2)) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (armed),
        .restart_i (kick),
        .ovf_o     (ovf)
    );

    wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (second_hit),
        .rst_o   (wdt_rst)
    );

    always_comb begin
        ctl_d      = ctl_q;
        second_hit = 1'b0;
        if (wr_ctrl) begin
            if (!(locked && !bus_wdata[BIT_EN1])) ctl_d.en1 = bus_wdata[BIT_EN1];
            if (bus_wdata[BIT_STATE]) ctl_d.state = 1'b0;
            if (bus_wdata[BIT_RSTF])  ctl_d.rstf  = 1'b0;
        end
        if (wr_arm) begin
            if (!(locked && !bus_wdata[BIT_EN2])) ctl_d.en2 = bus_wdata[BIT_EN2];
        end
        if (ovf) begin
            if (ctl_q.state) begin
                ctl_d.rstf = 1'b1;
                second_hit = 1'b1;
            end else begin
                ctl_d.state = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[BIT_RSTF]  = ctl_q.rstf;
            bus_rdata[BIT_STATE] = ctl_q.state;
            bus_rdata[BIT_EN1]   = ctl_q.en1;
            bus_rdata[BIT_EN2]   = ctl_q.en2;
        end else if (sel_arm) begin
            bus_rdata[0] = ctl_q.en2;
        end else if (sel_tbase) begin
            bus_rdata = 32'(tb_value);
        end
    end

    assign irq = ctl_q.state;

    assert_state_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.state) |-> $past(armed));
    assert_rstf_after_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.rstf) |-> $past(ctl_q.state));
    assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[BIT_STATE]) |=> !irq);
    assert_zero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[BIT_STATE] && ctl_q.state) |=> ctl_q.state);
    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ENABLE_ONCE && armed) |=> armed);
endmodule

// File: tb/tb_wdt_twostage.sv
module tb_wdt_twostage;
    localparam int N    = 6;
    localparam int ITV  = 1 << N;
    localparam int RSTC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, lock_rdata;
    logic        irq, wdt_rst, lock_irq, lock_rst;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdt_twostage #(.INTERVAL_LOG2(N), .RST_CYCLES(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst));

    wdt_twostage #(.INTERVAL_LOG2(N), .RST_CYCLES(RSTC), .ENABLE_ONCE(1'b1)) dut_lock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(lock_rdata), .irq(lock_irq), .wdt_rst(lock_rst));

    // Behavioural reference model of the unlocked instance
    bit          m_en1, m_en2, m_st, m_rf;
    int          m_cnt, m_pulse;
    logic [31:0] m_tb;
    bit          t_armed, t_kick, t_ovf, t_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en1 = 0; m_en2 = 0; m_st = 0; m_rf = 0;
            m_cnt = 0; m_pulse = 0; m_tb = 0;
        end else begin
            t_armed = m_en1 && m_en2;
            t_kick  = bus_wr && bus_addr == 4'h0 && (bus_wdata[2] || bus_wdata[3]);
            t_ovf   = t_armed && !t_kick && (m_cnt == ITV - 1);
            t_st    = m_st;
            if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (bus_wr && bus_addr == 4'h0) begin
                m_en1 = bus_wdata[1];
                if (bus_wdata[2]) m_st = 0;
                if (bus_wdata[3]) m_rf = 0;
            end
            if (bus_wr && bus_addr == 4'h4) m_en2 = bus_wdata[0];
            if (t_ovf) begin
                if (t_st) begin m_rf = 1; m_pulse = RSTC; end
                else m_st = 1;
            end
            m_cnt = (t_kick || !t_armed) ? 0 : (m_cnt + 1) % ITV;
            m_tb  = m_tb + 1;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0:    return {28'd0, m_rf, m_st, m_en1, m_en2};
            4'h4:    return {31'd0, m_en2};
            4'h8:    return m_tb;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 irq follows state flag", {31'd0, irq}, {31'd0, m_st});
            chk("R5 reset pulse", {31'd0, wdt_rst}, {31'd0, (m_pulse != 0)});
            chk("R1 read data", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_at(input logic [3:0] a);
        bus_addr = a;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [31:0] v1;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        rd_at(4'h0); chk("R1 reset control word", bus_rdata, 32'h0);
        rd_at(4'h4); chk("R1 reset arm word", bus_rdata, 32'h0);
        rd_at(4'hC); chk("R1 unmapped reads zero", bus_rdata, 32'h0);
        rd_at(4'h8); v1 = bus_rdata;
        rd_at(4'h8); chk("R2 timebase moves", {31'd0, (bus_rdata != v1)}, 32'd1);
        idle(1);
        // R3: only one enable set, no expiry
        wr(4'h0, 32'h2); idle(3 * ITV);
        rd_at(4'h0); chk("R3 single enable does not count", bus_rdata, 32'h2);
        // R4: arm, first expiry
        wr(4'h4, 32'h1); idle(ITV + 6);
        rd_at(4'h0); chk("R4 first expiry sets state", bus_rdata, 32'h7);
        chk("R4 irq raised", {31'd0, irq}, 32'd1);
        // R7: zero flag bits change nothing
        wr(4'h0, 32'h2);
        rd_at(4'h0); chk("R7 zero write keeps flags", bus_rdata, 32'h7);
        // R9 / R6: service write
        wr(4'h0, 32'h6);
        @(negedge clk); #1;
        chk("R9 irq drops after clear", {31'd0, irq}, 32'd0);
        // R5: two expiries without service
        idle(2 * ITV + 12);
        rd_at(4'h0); chk("R5 reset status latched", bus_rdata, 32'hF);
        wr(4'h0, 32'hE);
        rd_at(4'h0); chk("R6 both flags cleared", bus_rdata, 32'h3);
        // R3: disarm; R8: locked instance ignores it
        wr(4'h4, 32'h0); idle(3 * ITV);
        rd_at(4'h0); chk("R3 disarmed stays quiet", bus_rdata, 32'h2);
        chk("R8 locked keeps enable two", {31'd0, lock_rdata[0]}, 32'd1);
        wr(4'h0, 32'h0);
        rd_at(4'h0); chk("R8 locked keeps enable one", {31'd0, lock_rdata[1]}, 32'd1);
        chk("R3 unlocked enable one cleared", {31'd0, bus_rdata[1]}, 32'd0);
        wr(4'h0, 32'h2);
        // R6: service write in the exact expiry cycle wins
        wr(4'h4, 32'h1); idle(ITV - 1);
        wr(4'h0, 32'h6);
        @(negedge clk); #1;
        chk("R6 service beats expiry", {31'd0, irq}, 32'd0);
        rd_at(4'h0); chk("R6 flags stay clear", bus_rdata, 32'h3);
        idle(10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule